// File: doc/BRIEF.md
# Processor Supervisor Reset and Watchdog Sequencer

This block sequences the reset of a processor from two sources. The first is a low-line indication, already synchronised, from an external supply comparator. The second is a watchdog that expects the processor to toggle a strobe pin. While the supply is low, and for a fixed number of timebase ticks after it recovers, the block holds reset. Whenever the strobe stays quiet for a full timeout period, it issues a reset pulse of the same length. The timebase is a one-cycle tick from either an internal or an external source, and a select input chooses which one drives every counter.

After every reset the watchdog allows a long grace period. It moves to its normal period only once the processor has shown it is alive by toggling the strobe. With the external timebase the normal period is short. With the internal timebase a select input picks a short or a long normal period.

The block also drives three status and gating outputs. A low-line status output mirrors the comparator input without delay. A sticky watchdog status output goes low on a timeout. A chip-enable output is blocked high while the supply is low, which protects battery-backed memory from writes.

Top module: `supv_ctrl`

## Requirements
- R1: Reset (rst_n_o low) is held while low_line_i is 1 and at power-on. After low_line_i returns to 0, or after rst_n is released, reset stays low for exactly RST_TICKS selected ticks and then goes high.
- R2: rst_o is always the complement of rst_n_o.
- R3: low_line_n_o equals the inverse of low_line_i combinationally, in the same cycle and with no register in the path.
- R4: ce_n_o equals ce_n_i while low_line_i is 0. It is 1 whenever low_line_i is 1, whatever the level of ce_n_i.
- R5: Once reset ends, the watchdog runs its post-reset period. This is EXT_LONG ticks when ext_tb_i is 1 and INT_LONG ticks when ext_tb_i is 0.
- R6: The first strobe edge after reset ends switches the watchdog to its normal period. This is EXT_SHORT ticks with ext_tb_i=1. With ext_tb_i=0 it is INT_SHORT ticks when short_sel_i=1 and INT_LONG ticks when short_sel_i=0. A strobe change restarts the count on the third clock edge after the change (two synchroniser flops plus the edge register).
- R7: Every rising or falling strobe edge restarts the count. A strobe toggled more often than the period prevents any reset.
- R8: When the count expires, the block drives a reset pulse of RST_TICKS ticks. With the strobe idle, the pulses repeat once per post-reset period.
- R9: wdo_n_o goes to 0 on the clock edge at which a timeout starts reset, and stays 0 until a strobe edge takes effect. It is forced to 1 one clock after low_line_i is 1.
- R10: With wd_en_i=0 no timeout ever occurs, and wdo_n_o is 1 from the next clock on.
- R11: A strobe edge that takes effect in the same cycle as the count expiry counts as service. No reset follows, and the count restarts from that cycle.
- R12: Only the tick selected by ext_tb_i (1 = tick_ext_i, 0 = tick_int_i) advances the reset and watchdog counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| low_line_i | input | 1 | Synchronised low-supply indication, 1 = supply low |
| wd_strobe_i | input | 1 | Watchdog strobe from the processor, asynchronous |
| wd_en_i | input | 1 | 1 = watchdog active, 0 = strobe undriven (watchdog off) |
| ext_tb_i | input | 1 | Timebase select, 1 = external tick, 0 = internal tick |
| tick_int_i | input | 1 | One-cycle tick of the internal timebase |
| tick_ext_i | input | 1 | One-cycle tick of the external timebase |
| short_sel_i | input | 1 | Internal timebase only: 1 = short normal period |
| ce_n_i | input | 1 | Active-low chip enable from the processor |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset |
| low_line_n_o | output | 1 | Low-line status, 0 while supply is low |
| wdo_n_o | output | 1 | Watchdog status, 0 after a timeout |
| ce_n_o | output | 1 | Gated active-low chip enable |

## Verification
The bench scales the tick counts down to a reset length of 8, external periods of 16 and 40, and internal periods of 12 and 32. Every reset and timeout window, including repeated pulses and both period choices of each timebase, then finishes within a few hundred cycles. The internal short and long values differ, so a wrong choice of period shows up as a wrong count. With a tick every cycle, the exact expiry cycle can be placed under a strobe edge to exercise the tie rule. A run with a sparse external tick and a constant internal tick shows that only the selected source advances the counters.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;
   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   typedef enum logic {
      WD_POST_RESET = 1'b0,
      WD_NORMAL     = 1'b1
   } wd_phase_e;
endpackage

// File: rtl/supv_sync.sv
`timescale 1ns/1ps
module supv_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic edge_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("supv_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], d_i};
   end

   assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/supv_rst_timer.sv
`timescale 1ns/1ps
module supv_rst_timer
   import supv_pkg::*;
#(
   parameter int unsigned TICKS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic low_line_i,
   input  logic start_i,
   output logic active_o
);
   localparam int unsigned CW = bits_for(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   generate
      if (TICKS < 2) begin : g_bad_ticks
         $error("supv_rst_timer: TICKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (low_line_i || start_i) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (act_q && tick_i) begin
         if (cnt_q == LAST) begin
            act_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign active_o = act_q;

   assert_ll_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      low_line_i |=> active_o);

   assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !low_line_i && !start_i && act_q) |=> ($stable(cnt_q) && act_q));
endmodule

// File: rtl/supv_wdog.sv
`timescale 1ns/1ps
module supv_wdog
   import supv_pkg::*;
#(
   parameter int unsigned EXT_SHORT = 1024,
   parameter int unsigned EXT_LONG  = 4096,
   parameter int unsigned INT_SHORT = 1024,
   parameter int unsigned INT_LONG  = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ext_tb_i,
   input  logic short_sel_i,
   input  logic en_i,
   input  logic edge_i,
   input  logic hold_i,
   input  logic low_line_i,
   output logic fire_o,
   output logic wdo_n_o
);
   localparam int unsigned LMAX = max2(max2(EXT_SHORT, EXT_LONG), max2(INT_SHORT, INT_LONG));
   localparam int unsigned CW   = bits_for(LMAX);
   localparam logic [CW-1:0] ES_LAST = CW'(EXT_SHORT - 1);
   localparam logic [CW-1:0] EL_LAST = CW'(EXT_LONG - 1);
   localparam logic [CW-1:0] IS_LAST = CW'(INT_SHORT - 1);
   localparam logic [CW-1:0] IL_LAST = CW'(INT_LONG - 1);

   generate
      if (EXT_SHORT < 2 || INT_SHORT < 2) begin : g_bad_short
         $error("supv_wdog: short periods must be at least 2 ticks");
      end
      if (EXT_LONG < EXT_SHORT || INT_LONG < INT_SHORT) begin : g_bad_long
         $error("supv_wdog: long period shorter than short period");
      end
   endgenerate

   wd_phase_e     phase_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;
   logic          run;
   logic          wdo_q;

   always_comb begin
      if (phase_q == WD_POST_RESET) last = ext_tb_i ? EL_LAST : IL_LAST;
      else if (ext_tb_i)            last = ES_LAST;
      else                          last = short_sel_i ? IS_LAST : IL_LAST;
   end

   assign run    = en_i && !hold_i;
   assign fire_o = run && tick_i && !edge_i && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= WD_POST_RESET;
         cnt_q   <= '0;
      end else if (hold_i) begin
         phase_q <= WD_POST_RESET;
         cnt_q   <= '0;
      end else if (!en_i) begin
         cnt_q   <= '0;
      end else if (edge_i) begin
         phase_q <= WD_NORMAL;
         cnt_q   <= '0;
      end else if (tick_i) begin
         cnt_q   <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     wdo_q <= 1'b1;
      else if (low_line_i || !en_i)   wdo_q <= 1'b1;
      else if (edge_i)                wdo_q <= 1'b1;
      else if (fire_o)                wdo_q <= 1'b0;
   end

   assign wdo_n_o = wdo_q;

   assert_wdo_ll_R9: assert property (@(posedge clk) disable iff (!rst_n)
      low_line_i |=> wdo_n_o);

   assert_wdo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdo_n_o && !edge_i && !low_line_i && en_i) |=> !wdo_n_o);

   assert_no_fire_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !fire_o);

   assert_edge_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i |-> !fire_o);

   assert_hold_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (phase_q == WD_POST_RESET));
endmodule

// File: rtl/supv_ctrl.sv
`timescale 1ns/1ps
module supv_ctrl #(
   parameter int unsigned RST_TICKS   = 512,
   parameter int unsigned EXT_SHORT   = 1024,
   parameter int unsigned EXT_LONG    = 4096,
   parameter int unsigned INT_SHORT   = 1024,
   parameter int unsigned INT_LONG    = 16384,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low_line_i,
   input  logic wd_strobe_i,
   input  logic wd_en_i,
   input  logic ext_tb_i,
   input  logic tick_int_i,
   input  logic tick_ext_i,
   input  logic short_sel_i,
   input  logic ce_n_i,
   output logic rst_n_o,
   output logic rst_o,
   output logic low_line_n_o,
   output logic wdo_n_o,
   output logic ce_n_o
);
   logic tick;
   logic strobe_edge;
   logic rst_active;
   logic wd_fire;

   assign tick = ext_tb_i ? tick_ext_i : tick_int_i;

   supv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (wd_strobe_i),
      .edge_o(strobe_edge)
   );

   supv_rst_timer #(.TICKS(RST_TICKS)) u_rst_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .low_line_i(low_line_i),
      .start_i   (wd_fire),
      .active_o  (rst_active)
   );

   supv_wdog #(
      .EXT_SHORT(EXT_SHORT),
      .EXT_LONG (EXT_LONG),
      .INT_SHORT(INT_SHORT),
      .INT_LONG (INT_LONG)
   ) u_wdog (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .ext_tb_i   (ext_tb_i),
      .short_sel_i(short_sel_i),
      .en_i       (wd_en_i),
      .edge_i     (strobe_edge),
      .hold_i     (rst_active),
      .low_line_i (low_line_i),
      .fire_o     (wd_fire),
      .wdo_n_o    (wdo_n_o)
   );

   assign rst_n_o      = !rst_active;
   assign rst_o        = rst_active;
   assign low_line_n_o = !low_line_i;
   assign ce_n_o       = ce_n_i || low_line_i;

   assert_fire_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wd_fire |=> (!rst_n_o && !wdo_n_o));
endmodule

// File: tb/supv_ctrl_bench.sv
`timescale 1ns/1ps
module supv_ctrl_bench;
   localparam int RST = 8;
   localparam int ES  = 16;
   localparam int EL  = 40;
   localparam int IS  = 12;
   localparam int IL  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic low_line = 1'b0, strobe = 1'b0, wd_en = 1'b0, ext_tb = 1'b0;
   logic tick_int = 1'b1, short_sel = 1'b1, ce_n_in = 1'b1;
   logic sparse = 1'b0;
   int   tdiv = 0;
   logic rst_n_o, rst_o, low_line_n_o, wdo_n_o, ce_n_o;
   logic tick_ext;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      #1;
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
   end
   assign tick_ext = sparse ? (tdiv == 0) : 1'b1;

   supv_ctrl #(
      .RST_TICKS(RST), .EXT_SHORT(ES), .EXT_LONG(EL),
      .INT_SHORT(IS), .INT_LONG(IL), .SYNC_STAGES(2)
   ) u_supv_ctrl (
      .clk(clk), .rst_n(rst_n), .low_line_i(low_line), .wd_strobe_i(strobe),
      .wd_en_i(wd_en), .ext_tb_i(ext_tb), .tick_int_i(tick_int),
      .tick_ext_i(tick_ext), .short_sel_i(short_sel), .ce_n_i(ce_n_in),
      .rst_n_o(rst_n_o), .rst_o(rst_o), .low_line_n_o(low_line_n_o),
      .wdo_n_o(wdo_n_o), .ce_n_o(ce_n_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // counts selected ticks until reset releases; called at a negedge
   task automatic wait_rst_high(output int n);
      n = 0;
      while (rst_n_o == 1'b0 && n < 100000) begin
         automatic int tk = ext_tb ? int'(tick_ext) : int'(tick_int);
         @(posedge clk); @(negedge clk);
         n += tk;
      end
      check("R2 complement", int'(rst_o), int'(!rst_n_o));
   endtask

   task automatic wait_rst_low(output int n);
      n = 0;
      while (rst_n_o == 1'b1 && n < 100000) begin
         automatic int tk = ext_tb ? int'(tick_ext) : int'(tick_int);
         @(posedge clk); @(negedge clk);
         n += tk;
      end
      check("R2 complement", int'(rst_o), int'(!rst_n_o));
   endtask

   task automatic ll_pulse();
      low_line = 1'b1;
      repeat (3) @(negedge clk);
      low_line = 1'b0;
   endtask

   task automatic t_reset_state();
      int n;
      repeat (3) @(negedge clk);
      check("R1 reset state rst_n_o", int'(rst_n_o), 0);
      check("R2 reset state rst_o", int'(rst_o), 1);
      check("R9 reset state wdo_n_o", int'(wdo_n_o), 1);
      rst_n = 1'b1;
      wait_rst_high(n);
      check("R1 power-on length", n, RST);
   endtask

   task automatic t_low_line();
      int n;
      repeat (4) @(negedge clk);
      low_line = 1'b1;
      #1;
      check("R3 status follows at once", int'(low_line_n_o), 0);
      repeat (20) @(negedge clk);
      check("R1 held during low line", int'(rst_n_o), 0);
      low_line = 1'b0;
      #1;
      check("R3 status clears at once", int'(low_line_n_o), 1);
      @(negedge clk);
      wait_rst_high(n);
      check("R1 length after recovery", n + 1, RST);
   endtask

   task automatic t_ce_gate();
      int n;
      ce_n_in = 1'b0; #1;
      check("R4 ce passes 0", int'(ce_n_o), 0);
      ce_n_in = 1'b1; #1;
      check("R4 ce passes 1", int'(ce_n_o), 1);
      @(negedge clk);
      low_line = 1'b1; ce_n_in = 1'b0; #1;
      check("R4 ce blocked in low line", int'(ce_n_o), 1);
      @(negedge clk);
      low_line = 1'b0; ce_n_in = 1'b1;
      wait_rst_high(n);
   endtask

   task automatic t_int_long_idle();
      int n;
      wd_en = 1'b1; ext_tb = 1'b0; short_sel = 1'b1;
      ll_pulse();
      wait_rst_high(n);
      wait_rst_low(n);
      check("R5 internal post-reset period", n, IL);
      check("R9 wdo low on timeout", int'(wdo_n_o), 0);
      wait_rst_high(n);
      check("R8 pulse length", n, RST);
      check("R9 wdo sticky after pulse", int'(wdo_n_o), 0);
      wait_rst_low(n);
      check("R8 repeat period", n, IL);
      wait_rst_high(n);
   endtask

   task automatic t_int_normal(input logic sel, input int exp, input string tag);
      int n;
      short_sel = sel;
      strobe = ~strobe;
      wait_rst_low(n);
      check(tag, n, exp);
      strobe = ~strobe;
      repeat (3) @(negedge clk);
      check("R9 edge clears wdo", int'(wdo_n_o), 1);
      wait_rst_high(n);
   endtask

   task automatic t_service();
      int drops = 0, wlow = 0;
      for (int i = 0; i < 300; i++) begin
         if (i % 5 == 0) strobe = ~strobe;
         @(negedge clk);
         if (!rst_n_o) drops++;
         if (!wdo_n_o) wlow++;
      end
      check("R7 no reset while serviced", drops, 0);
      check("R7 wdo high while serviced", wlow, 0);
   endtask

   task automatic t_tie();
      int n;
      ll_pulse();
      wait_rst_high(n);
      short_sel = 1'b1;
      strobe = ~strobe;
      repeat (IS) @(posedge clk);
      @(negedge clk);
      strobe = ~strobe;
      wait_rst_low(n);
      check("R11 edge at expiry is service", n, IS + 3);
      wait_rst_high(n);
   endtask

   task automatic t_disable_and_ll();
      int n, drops = 0;
      wait_rst_low(n);
      check("R9 timeout before low line", int'(wdo_n_o), 0);
      low_line = 1'b1;
      @(negedge clk);
      check("R9 low line forces wdo high", int'(wdo_n_o), 1);
      low_line = 1'b0;
      wait_rst_high(n);
      wait_rst_low(n);
      wait_rst_high(n);
      check("R9 wdo low before disable", int'(wdo_n_o), 0);
      wd_en = 1'b0;
      @(negedge clk);
      check("R10 disable forces wdo high", int'(wdo_n_o), 1);
      for (int i = 0; i < 3 * IL; i++) begin
         @(negedge clk);
         if (!rst_n_o || !wdo_n_o) drops++;
      end
      check("R10 no timeout when disabled", drops, 0);
   endtask

   task automatic t_ext();
      int n;
      wd_en = 1'b1; ext_tb = 1'b1; short_sel = 1'b0;
      ll_pulse();
      wait_rst_high(n);
      strobe = ~strobe;
      wait_rst_low(n);
      check("R6 external normal period", n, ES + 3);
      wait_rst_high(n);
      wait_rst_low(n);
      check("R5 external post-reset period", n, EL);
      sparse = 1'b1;
      wait_rst_high(n);
      check("R12 sparse tick reset length", n, RST);
      wait_rst_low(n);
      check("R12 sparse tick post-reset period", n, EL);
      wait_rst_high(n);
      sparse = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_low_line();
      t_ce_gate();
      t_int_long_idle();
      t_int_normal(1'b1, IS + 3, "R6 internal short normal period");
      t_int_normal(1'b0, IL + 3, "R6 internal long normal period");
      t_service();
      t_tie();
      t_disable_and_ll();
      t_ext();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule